// File: doc/BRIEF.md
# Infrared Receive Pulse Stretcher

This block turns the short, active-low pulses from a serial infrared receiver back into the non-return-to-zero level that a UART receiver expects. Each pulse the receiver delivers marks one zero bit. The block holds its UART receive output low for exactly one bit time at the programmed rate. The length of the received pulse has no influence on that time.

The bit time is given as a count of clock cycles on the `bit_period` input, normally taken from a baud generator. The block can also ignore pulses that arrive while the local UART is sending a zero. This removes the optical echo that many transceivers place on their receive line during transmission. A control input enables or disables this echo gating. An active-low indicator output follows the decoded data so that it can drive an activity lamp.

Top module: `irda_rx_stretcher`

## Requirements
- R1: While reset is asserted and after it is released, with no pulse received, `uart_rx` and `rx_led_n` are both 1.
- R2: A falling edge on `ir_rx_n` passes through a two-flop synchroniser. Suppose `ir_rx_n` is first low at clock edge e0. Then `uart_rx` goes low after edge e0+2. An edge is accepted only when the synchronised input was high on the sample before.
- R3: After one accepted edge, `uart_rx` stays low for exactly `bit_period` clock cycles and then returns to 1. A `bit_period` of 0 acts as 1.
- R4: The low time of `uart_rx` is the same for a one-cycle input pulse as for an input held low far longer than the bit time. A level that stays low does not start a second bit.
- R5: A new accepted edge while `uart_rx` is low restarts the count. `uart_rx` then stays low until `bit_period` cycles after the last accepted edge, as one unbroken low level.
- R6: When `echo_gate_en` is 1 and `uart_tx` is 0 (the local transmitter is sending a zero) in the cycle an edge would be accepted, the edge is dropped and `uart_rx` stays 1.
- R7: When `echo_gate_en` is 0, the level of `uart_tx` has no effect on `uart_rx`.
- R8: `rx_led_n` equals `uart_rx` in every cycle.
- R9: `bit_period` is sampled when an edge is accepted. A change of `bit_period` while `uart_rx` is low does not alter the length of that low level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_rx_n | input | 1 | Pulse line from the infrared receiver, active low, asynchronous |
| bit_period | input | CNT_W | Bit time in clock cycles, sampled at each accepted edge |
| uart_tx | input | 1 | Local UART transmit line, idle high |
| echo_gate_en | input | 1 | 1 = drop pulses while `uart_tx` is low |
| uart_rx | output | 1 | Decoded NRZ receive data, idle high |
| rx_led_n | output | 1 | Receive activity indicator, active low |

## Verification
The bench builds the block with an 8-bit `bit_period`. Short bit times such as 0, 1, 5 and 8 cycles then reach the expiry, the restart and the zero-period boundaries within a few dozen cycles. A single test run can also drive a pulse that lasts several bit times.

A behavioural model of the history of the input and a countdown predicts `uart_rx` and `rx_led_n` on every clock. Measured latency and low-time values are checked against R2 to R9. Echo gating is tested with the gate enabled and disabled, and with `uart_tx` high and low.

// File: rtl/irda_rx_pkg.sv
package irda_rx_pkg;
  // Event produced by the edge stage for the timer
  typedef struct packed {
    logic fall;     // synchronised high-to-low transition
    logic blocked;  // echo gate is closing the path this cycle
  } rx_event_t;
endpackage

// File: rtl/irda_rx_sync.sv
module irda_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/irda_rx_edge.sv
module irda_rx_edge
  import irda_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync_i,
  input  logic      echo_gate_en_i,
  input  logic      uart_tx_i,
  output rx_event_t ev_o,
  output logic      accept_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_i;
  end

  assign ev_o.fall    = prev_q & ~sync_i;
  assign ev_o.blocked = echo_gate_en_i & ~uart_tx_i;
  assign accept_o     = ev_o.fall & ~ev_o.blocked;
endmodule

// File: rtl/irda_rx_timer.sv
module irda_rx_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [CNT_W-1:0] bit_period_i,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // A zero period is stretched to one cycle so every accepted edge shows up
  function automatic logic [CNT_W-1:0] load_value(input logic [CNT_W-1:0] p);
    return (p == '0) ? ONE : p;
  endfunction

  logic [CNT_W-1:0] rem_q;
  logic             active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q    <= '0;
      active_q <= 1'b0;
    end else if (accept_i) begin
      rem_q    <= load_value(bit_period_i);
      active_q <= 1'b1;
    end else if (active_q) begin
      if (rem_q == ONE) begin
        rem_q    <= '0;
        active_q <= 1'b0;
      end else begin
        rem_q <= rem_q - ONE;
      end
    end
  end

  assign active_o = active_q;

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_i |=> active_q);

  assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !accept_i && rem_q > ONE) |=> (active_q && rem_q == $past(rem_q) - ONE));

  assert_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !accept_i && rem_q == ONE) |=> !active_q);

  assert_no_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !accept_i) |=> !active_q);
endmodule

// File: rtl/irda_rx_stretcher.sv
module irda_rx_stretcher
  import irda_rx_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ir_rx_n,
  input  logic [CNT_W-1:0] bit_period,
  input  logic             uart_tx,
  input  logic             echo_gate_en,
  output logic             uart_rx,
  output logic             rx_led_n
);
  logic      ir_sync;
  rx_event_t ev;
  logic      accept;
  logic      active;

  irda_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ir_rx_n),
    .sync_o  (ir_sync)
  );

  irda_rx_edge u_edge (
    .clk            (clk),
    .rst_n          (rst_n),
    .sync_i         (ir_sync),
    .echo_gate_en_i (echo_gate_en),
    .uart_tx_i      (uart_tx),
    .ev_o           (ev),
    .accept_o       (accept)
  );

  irda_rx_timer #(.CNT_W(CNT_W)) u_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept),
    .bit_period_i (bit_period),
    .active_o     (active)
  );

  assign uart_rx  = ~active;
  assign rx_led_n = ~active;

  assert_echo_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_gate_en && !uart_tx && uart_rx) |=> uart_rx);

  assert_edge_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.fall && !ev.blocked) |=> !uart_rx);
endmodule

// File: tb/sim_irda_rx_stretcher.sv
module sim_irda_rx_stretcher;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ir_rx_n = 1'b1;
  logic          uart_tx = 1'b1;
  logic          echo_gate_en = 1'b0;
  logic [CW-1:0] bit_period = CW'(5);
  logic          uart_rx, rx_led_n;

  int    tests = 0, fails = 0;
  string cur_req = "R1";
  bit    done = 0;

  always #4 clk = ~clk;

  irda_rx_stretcher #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .ir_rx_n(ir_rx_n), .bit_period(bit_period),
    .uart_tx(uart_tx), .echo_gate_en(echo_gate_en),
    .uart_rx(uart_rx), .rx_led_n(rx_led_n)
  );

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reference model: past input samples and a countdown of remaining low cycles
  int hist[$] = '{1, 1, 1};
  int rem_m = 0;
  int acc_m;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{1, 1, 1};
      rem_m = 0;
    end else begin
      acc_m = (hist[2] == 1 && hist[1] == 0 && !(echo_gate_en && !uart_tx)) ? 1 : 0;
      if (acc_m != 0) rem_m = (bit_period == 0) ? 1 : int'(bit_period);
      else if (rem_m > 0) rem_m--;
      hist.push_front(int'(ir_rx_n));
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(uart_rx == (rem_m == 0), cur_req, int'(uart_rx), int'(rem_m == 0));
      check(rx_led_n == (rem_m == 0), "R8", int'(rx_led_n), int'(rem_m == 0));
    end
  end

  // Drive one or two pulses from a negedge and measure latency and low time
  task automatic pulse(int w, int gap, int chg_at, int chg_val,
                       output int lat, output int len);
    lat = -1;
    len = 0;
    ir_rx_n = 1'b0;
    for (int i = 1; i <= 60; i++) begin
      @(negedge clk);
      ir_rx_n = ((i < w) || (gap > 0 && i >= gap && i < gap + w)) ? 1'b0 : 1'b1;
      if (i == chg_at) bit_period = CW'(chg_val);
      if (uart_rx == 1'b0) begin
        if (lat < 0) lat = i;
        len++;
      end
    end
    ir_rx_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int lat, len;
    repeat (3) @(negedge clk);
    check(uart_rx == 1'b1, "R1", int'(uart_rx), 1);
    check(rx_led_n == 1'b1, "R1", int'(rx_led_n), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(uart_rx == 1'b1, "R1", int'(uart_rx), 1);

    cur_req = "R2";
    bit_period = CW'(5);
    pulse(2, 0, 0, 0, lat, len);
    check(lat == 3, "R2", lat, 3);
    check(len == 5, "R3", len, 5);

    cur_req = "R4";
    pulse(1, 0, 0, 0, lat, len);
    check(len == 5, "R4", len, 5);
    pulse(30, 0, 0, 0, lat, len);
    check(len == 5, "R4", len, 5);

    cur_req = "R3";
    bit_period = CW'(1);
    pulse(2, 0, 0, 0, lat, len);
    check(len == 1, "R3", len, 1);
    bit_period = CW'(0);
    pulse(2, 0, 0, 0, lat, len);
    check(len == 1, "R3", len, 1);

    cur_req = "R5";
    bit_period = CW'(8);
    pulse(1, 3, 0, 0, lat, len);
    check(len == 11, "R5", len, 11);
    pulse(1, 6, 0, 0, lat, len);
    check(len == 14, "R5", len, 14);

    cur_req = "R9";
    bit_period = CW'(6);
    pulse(2, 0, 4, 20, lat, len);
    check(len == 6, "R9", len, 6);

    cur_req = "R6";
    bit_period = CW'(5);
    echo_gate_en = 1'b1;
    uart_tx = 1'b0;
    pulse(2, 0, 0, 0, lat, len);
    check(len == 0, "R6", len, 0);
    uart_tx = 1'b1;
    pulse(2, 0, 0, 0, lat, len);
    check(len == 5, "R6", len, 5);

    cur_req = "R7";
    echo_gate_en = 1'b0;
    uart_tx = 1'b0;
    pulse(2, 0, 0, 0, lat, len);
    check(len == 5, "R7", len, 5);
    check(lat == 3, "R7", lat, 3);
    uart_tx = 1'b1;

    done = 1;
    summary();
    $finish;
  end
endmodule